// File: doc/BRIEF.md
# Vectored Bus Interrupter (four sources)

This block connects four plug-in module interrupt sources to a system bus that has seven prioritised, active-low interrupt request lines. Each source has two write-only registers, both loaded through one register-write port. The control register holds a request level, an enable, an auto-clear option and a response-mode select. The vector register holds an 8-bit identification byte. A 3-bit switch input for each source fixes the level in hardware. Its all-on code selects the level programmed in the control register instead.

When the bus runs an interrupt acknowledge, it presents the level being serviced and holds an acknowledge strobe. The block picks the lowest-numbered enabled, pending source at that level. It then does one of two things. It returns that source's vector with a data-acknowledge strobe. Or it raises a one-hot hand-off to the module so the module can answer itself. If no source qualifies, the acknowledge is passed on down the daisy chain. The response holds until the strobe drops.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every control register is cleared. After that edge `irq_n` is all ones and `dtack`, `vec_out`, `mod_ack` and `ack_pass` are zero.
- R2: A source's effective level is its switch code when that code is nonzero. A switch code of 3'b000 (all switches on) selects control bits [2:0]. An effective level of 0 never requests.
- R3: `irq_n[k]` is low one clock after any source is enabled, has its `mod_req` bit high and has effective level k+1. It stays low only while such a source remains.
- R4: With control bit 4 (enable) at 0, a source raises no request line and is never selected by an acknowledge.
- R5: On the first clock that samples `ack_strobe` high, the source selected is the lowest-numbered source that is enabled, pending and at level `ack_lvl`.
- R6: If the selected source has control bit 5 at 0, `dtack` is 1 and `vec_out` carries that source's vector from the next clock. `mod_ack` stays zero.
- R7: If the selected source has control bit 5 at 1, `mod_ack` is one-hot for that source from the next clock, while `dtack` and `vec_out` stay zero.
- R8: If no source qualifies at an acknowledge, `ack_pass` is 1 from the next clock and no other response is given.
- R9: The response is decided once for each strobe. It holds unchanged while `ack_strobe` stays high. It is cleared at the first clock that samples `ack_strobe` low.
- R10: If the selected source has control bit 3 (auto-clear) set, its enable bit is cleared at the selecting clock. The enable stays 0 until written again. A control write to that source at the same clock takes precedence.
- R11: Control bits 7:6 have no effect on any output.
- R12: Each source has its own vector register. It is not cleared by reset and changes only when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high bus reset |
| wr_en | input | 1 | Register write strobe |
| wr_is_vec | input | 1 | 1 writes the vector register, 0 writes the control register |
| wr_src | input | 2 | Source index of the write |
| wr_data | input | 8 | Write data |
| mod_req | input | 4 | Module interrupt requests, active high, bit i for source i |
| sw_lvl | input | 12 | Switch level per source, bits [3i+2:3i]; 0 selects the software level |
| ack_strobe | input | 1 | Acknowledge strobe from the bus, active high |
| ack_lvl | input | 3 | Level being acknowledged |
| irq_n | output | 7 | Active-low request lines, bit k is level k+1 |
| dtack | output | 1 | Data acknowledge for an internal response |
| vec_out | output | 8 | Vector byte, zero unless `dtack` is high |
| mod_ack | output | 4 | One-hot hand-off of the acknowledge to a module |
| ack_pass | output | 1 | Acknowledge passed downstream |

## Verification
The request lines change one clock after the request, enable, level or switch input that moves them. An acknowledge response appears one clock after the first edge that samples the strobe high. It clears one clock after the first edge that samples the strobe low. An auto-clear enable drop shows on the request lines one clock after the acknowledge edge. The bench drives all inputs on the falling edge. A behavioural model advances on each rising edge, and all five outputs are compared against it on every falling edge, so every one of those latencies is checked in the exact cycle where it falls due. Directed phases cover priority, both response modes, pass-through, hold, auto-clear and re-arm, and reserved bits. A long randomised phase then mixes writes, requests, switch codes and acknowledges of varying length.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int LVL_W = 3;
  localparam int NUM_LVL = (1 << LVL_W) - 1;
  localparam int BYTE_W = 8;

  // control register image; reserved bits 7:6 are not stored
  typedef struct packed {
    logic             xin;   // bit 5: hand acknowledge to the module
    logic             ire;   // bit 4: request enable
    logic             irac;  // bit 3: drop enable on acknowledge
    logic [LVL_W-1:0] lvl;   // bits 2:0: software level
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_is_vec,
  input  logic [SRC_W-1:0]      wr_src,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic                  clr_en,
  input  logic [SRC_W-1:0]      clr_src,
  input  logic [SRC_W-1:0]      rd_src,
  output logic [BYTE_W-1:0]     rd_vec,
  output ctrl_t [NUM_SRC-1:0]   ctrl_q
);
  logic [BYTE_W-1:0] vec_mem [NUM_SRC];
  logic ctrl_wr;

  assign ctrl_wr = wr_en && !wr_is_vec;

  // vector storage: no reset, written only by the port
  always_ff @(posedge clk) begin
    if (wr_en && wr_is_vec) vec_mem[wr_src] <= wr_data;
  end

  assign rd_vec = vec_mem[rd_src];

  // control registers: auto-clear first, a write at the same edge overrides
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (clr_en) ctrl_q[clr_src].ire <= 1'b0;
      if (ctrl_wr) ctrl_q[wr_src] <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R10
    autoclr_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_en && clr_src == SRC_W'(i) && !(ctrl_wr && wr_src == SRC_W'(i)))
      |=> !ctrl_q[i].ire);
  end
endmodule

// File: rtl/vic_level_map.sv
module vic_level_map
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrl_t [NUM_SRC-1:0]           ctrl_q,
  input  logic [NUM_SRC*LVL_W-1:0]      sw_lvl,
  input  logic [NUM_SRC-1:0]            mod_req,
  output logic [NUM_SRC-1:0][LVL_W-1:0] eff_lvl,
  output logic [NUM_SRC-1:0]            active,
  output logic [NUM_LVL-1:0]            irq_n
);
  logic [NUM_LVL-1:0] lvl_hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [LVL_W-1:0] sw;
    assign sw         = sw_lvl[i*LVL_W +: LVL_W];
    assign eff_lvl[i] = (sw == '0) ? ctrl_q[i].lvl : sw;
    assign active[i]  = mod_req[i] && ctrl_q[i].ire && (eff_lvl[i] != '0);
  end

  always_comb begin
    lvl_hit = '0;
    for (int k = 0; k < NUM_LVL; k++) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (active[i] && eff_lvl[i] == LVL_W'(k + 1)) lvl_hit[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= '1;
    else     irq_n <= ~lvl_hit;
  end

  // R4
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    (active == '0) |=> (irq_n == '1));
  // R3
  some_line_chk: assert property (@(posedge clk) disable iff (rst)
    (active != '0) |=> (irq_n != '1));
endmodule

// File: rtl/vic_ack.sv
module vic_ack
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrl_t [NUM_SRC-1:0]           ctrl_q,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] eff_lvl,
  input  logic [NUM_SRC-1:0]            active,
  input  logic                          ack_strobe,
  input  logic [LVL_W-1:0]              ack_lvl,
  input  logic [BYTE_W-1:0]             rd_vec,
  output logic [SRC_W-1:0]              rd_src,
  output logic                          clr_en,
  output logic [SRC_W-1:0]              clr_src,
  output logic                          dtack,
  output logic [BYTE_W-1:0]             vec_out,
  output logic [NUM_SRC-1:0]            mod_ack,
  output logic                          ack_pass
);
  logic [NUM_SRC-1:0] elig;
  logic [SRC_W-1:0]   win;
  logic               found;
  logic               busy_q;
  logic               capture;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = active[i] && (eff_lvl[i] == ack_lvl);
  end

  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win   = SRC_W'(i);
        found = 1'b1;
      end
    end
  end

  assign capture = ack_strobe && !busy_q;
  assign rd_src  = win;
  assign clr_src = win;
  assign clr_en  = capture && found && ctrl_q[win].irac;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      dtack    <= 1'b0;
      vec_out  <= '0;
      mod_ack  <= '0;
      ack_pass <= 1'b0;
    end else if (capture) begin
      busy_q <= 1'b1;
      if (!found) begin
        ack_pass <= 1'b1;
      end else if (ctrl_q[win].xin) begin
        mod_ack <= NUM_SRC'(1) << win;
      end else begin
        dtack   <= 1'b1;
        vec_out <= rd_vec;
      end
    end else if (!ack_strobe) begin
      busy_q   <= 1'b0;
      dtack    <= 1'b0;
      vec_out  <= '0;
      mod_ack  <= '0;
      ack_pass <= 1'b0;
    end
  end

  // R7
  resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dtack, (mod_ack != '0), ack_pass}));
  // R7
  handoff_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mod_ack));
  // R9
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_strobe |=> !(dtack || (mod_ack != '0) || ack_pass));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ack_strobe) |=> $stable({dtack, vec_out, mod_ack, ack_pass}));
  // R6
  dtack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dtack) |-> $past(ack_strobe));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_is_vec,
  input  logic [SRC_W-1:0]         wr_src,
  input  logic [7:0]               wr_data,
  input  logic [NUM_SRC-1:0]       mod_req,
  input  logic [NUM_SRC*3-1:0]     sw_lvl,
  input  logic                     ack_strobe,
  input  logic [2:0]               ack_lvl,
  output logic [6:0]               irq_n,
  output logic                     dtack,
  output logic [7:0]               vec_out,
  output logic [NUM_SRC-1:0]       mod_ack,
  output logic                     ack_pass
);
  ctrl_t [NUM_SRC-1:0]           ctrl_q;
  logic [NUM_SRC-1:0][LVL_W-1:0] eff_lvl;
  logic [NUM_SRC-1:0]            active;
  logic [SRC_W-1:0]              rd_src;
  logic [SRC_W-1:0]              clr_src;
  logic [BYTE_W-1:0]             rd_vec;
  logic                          clr_en;

  vic_regs #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_is_vec(wr_is_vec), .wr_src(wr_src), .wr_data(wr_data),
    .clr_en(clr_en), .clr_src(clr_src),
    .rd_src(rd_src), .rd_vec(rd_vec), .ctrl_q(ctrl_q)
  );

  vic_level_map #(.NUM_SRC(NUM_SRC)) u_map (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .sw_lvl(sw_lvl),
    .mod_req(mod_req), .eff_lvl(eff_lvl), .active(active), .irq_n(irq_n)
  );

  vic_ack #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_ack (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .eff_lvl(eff_lvl), .active(active),
    .ack_strobe(ack_strobe), .ack_lvl(ack_lvl), .rd_vec(rd_vec),
    .rd_src(rd_src), .clr_en(clr_en), .clr_src(clr_src),
    .dtack(dtack), .vec_out(vec_out), .mod_ack(mod_ack), .ack_pass(ack_pass)
  );
endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_is_vec = 1'b0;
  logic [1:0]  wr_src = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  mod_req = '0;
  logic [11:0] sw_lvl = '0;
  logic        ack_strobe = 1'b0;
  logic [2:0]  ack_lvl = '0;
  logic [6:0]  irq_n;
  logic        dtack;
  logic [7:0]  vec_out;
  logic [3:0]  mod_ack;
  logic        ack_pass;

  vec_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_is_vec(wr_is_vec), .wr_src(wr_src),
    .wr_data(wr_data), .mod_req(mod_req), .sw_lvl(sw_lvl), .ack_strobe(ack_strobe),
    .ack_lvl(ack_lvl), .irq_n(irq_n), .dtack(dtack), .vec_out(vec_out),
    .mod_ack(mod_ack), .ack_pass(ack_pass)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit    started = 0, done = 0;

  // reference model state
  int       m_lvl[NS], m_ire[NS], m_irac[NS], m_xin[NS], m_vec[NS];
  int       m_busy;
  int       e_irq, e_dtack, e_vec, e_mack, e_pass;

  always @(posedge clk) begin
    int eff[NS];
    int act[NS];
    int win;
    int nirq;
    started = 1;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin
        m_lvl[i] = 0; m_ire[i] = 0; m_irac[i] = 0; m_xin[i] = 0;
      end
      m_busy = 0; e_irq = 'h7f; e_dtack = 0; e_vec = 0; e_mack = 0; e_pass = 0;
    end else begin
      nirq = 'h7f;
      for (int i = 0; i < NS; i++) begin
        int sw;
        sw = (sw_lvl >> (3*i)) & 7;
        eff[i] = (sw != 0) ? sw : m_lvl[i];
        act[i] = (mod_req[i] && m_ire[i] != 0 && eff[i] != 0) ? 1 : 0;
        if (act[i] != 0) nirq = nirq & ~(1 << (eff[i] - 1));
      end
      if (ack_strobe && m_busy == 0) begin
        win = -1;
        for (int i = NS - 1; i >= 0; i--)
          if (act[i] != 0 && eff[i] == int'(ack_lvl)) win = i;
        m_busy = 1;
        if (win < 0) e_pass = 1;
        else begin
          if (m_xin[win] != 0) e_mack = 1 << win;
          else begin e_dtack = 1; e_vec = m_vec[win]; end
          if (m_irac[win] != 0) m_ire[win] = 0;
        end
      end else if (!ack_strobe) begin
        m_busy = 0; e_dtack = 0; e_vec = 0; e_mack = 0; e_pass = 0;
      end
      e_irq = nirq;
    end
    if (!rst && wr_en) begin
      if (wr_is_vec) m_vec[wr_src] = int'(wr_data);
      else begin
        m_lvl[wr_src]  = wr_data[2:0];
        m_irac[wr_src] = wr_data[3];
        m_ire[wr_src]  = wr_data[4];
        m_xin[wr_src]  = wr_data[5];
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s/%s act=%0h exp=%0h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R3 irq_n", int'(irq_n), e_irq);
      chk("R6 dtack", int'(dtack), e_dtack);
      chk("R6 vec_out", int'(vec_out), e_vec);
      chk("R7 mod_ack", int'(mod_ack), e_mack);
      chk("R8 ack_pass", int'(ack_pass), e_pass);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit isv, int src, int data);
    wr_en = 1'b1; wr_is_vec = isv; wr_src = 2'(src); wr_data = 8'(data);
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic ack(int lvl, int hold);
    ack_strobe = 1'b1; ack_lvl = 3'(lvl);
    cyc(hold);
    ack_strobe = 1'b0;
    cyc(2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    phase = "R1";
    chk("R1 irq_n idle", int'(irq_n), 'h7f);
    chk("R1 no response", int'({dtack, mod_ack, ack_pass}), 0);
    rst = 1'b0;
    cyc(1);
    phase = "R12";
    for (int i = 0; i < NS; i++) wr(1, i, 'hA0 + i);
    phase = "R2";
    wr(0, 0, 'h13);                    // enable, level 3
    mod_req = 4'b0001; cyc(3);
    chk("R3 line3 low", int'(irq_n[2]), 0);
    wr(0, 1, 'h12); sw_lvl = 12'h5 << 3; // switch overrides to level 5
    mod_req = 4'b0011; cyc(3);
    chk("R2 switch level", int'(irq_n[4]), 0);
    phase = "R4";
    wr(0, 2, 'h04);                    // level 4, not enabled
    mod_req = 4'b0111; cyc(2);
    ack(4, 3);
    phase = "R5";
    wr(0, 3, 'h13); mod_req = 4'b1111; cyc(2);
    ack(3, 2);                         // source 0 wins
    phase = "R7";
    wr(0, 0, 'h33); cyc(1);
    ack(3, 4);                         // source 0 handed to module
    phase = "R8";
    ack(6, 2);
    phase = "R9";
    ack_strobe = 1'b1; ack_lvl = 3'd5; cyc(2);
    mod_req = 4'b0000; cyc(3);         // response must hold
    ack_strobe = 1'b0; cyc(2);
    mod_req = 4'b1111;
    phase = "R10";
    wr(0, 3, 'h1B); wr(0, 0, 'h00); cyc(1);
    ack(3, 2);
    chk("R10 enable dropped", int'(irq_n[2]), 1);
    ack(3, 2);                         // passes now
    wr(0, 3, 'h1B); cyc(2);
    chk("R10 re-armed", int'(irq_n[2]), 0);
    // auto-clear and a same-edge rewrite: write wins
    ack_strobe = 1'b1; ack_lvl = 3'd3;
    wr_en = 1'b1; wr_is_vec = 1'b0; wr_src = 2'd3; wr_data = 8'h1B;
    cyc(1); wr_en = 1'b0; cyc(1); ack_strobe = 1'b0; cyc(2);
    phase = "R11";
    wr(0, 3, 'hD3); cyc(2);
    ack(3, 2);
    phase = "R12";
    wr(1, 2, 'h5C); wr(0, 2, 'h14); sw_lvl = '0; cyc(1);
    ack(4, 2);
    rst = 1'b1; cyc(2); rst = 1'b0;
    wr(0, 2, 'h14); cyc(1);
    ack(4, 2);                         // vector survives reset
    phase = "R5 random";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) wr(0, $urandom_range(0, 3), $urandom_range(0, 255));
      else if (r == 3) wr(1, $urandom_range(0, 3), $urandom_range(0, 255));
      else if (r == 4) begin mod_req = 4'($urandom_range(0, 15)); cyc(1); end
      else if (r == 5) begin
        sw_lvl = ($urandom_range(0, 3) == 0) ? 12'($urandom) : '0; cyc(1);
      end
      else ack($urandom_range(0, 7), $urandom_range(1, 4));
    end
    cyc(2);
    finish_run();
  end
endmodule